// File: doc/BRIEF.md
# Channel Command and Interrupt Register File

This block is the software-facing control point for a bank of DMA channel engines. Software writes a 2-bit command code per channel (start, pause or flush) into a command status register. It sets or clears bits without a read-modify-write, through separate write-one-to-set and write-one-to-clear views. The block decodes each channel's field into one-hot command outputs, gated by a command mask. It clears a field when the channel engine acknowledges it.

A second register group collects completion and error events from the channels into a sticky interrupt status. Software can also set or clear that status through the same set/clear views. One interrupt line is raised whenever an enabled status bit is pending. The register port is a plain single-cycle write strobe with a combinational read.

Top module: `chan_cmd_irq_regs`

## Requirements
- R1: After reset every status and mask register reads 0, all command outputs are 0 and `irq` is 0.
- R2: A write to the command set view (byte offset 0xFC4) ORs the written ones into command status. Reading offset 0xFC0, 0xFC4 or 0xFC8 returns the command status value.
- R3: A write to the command clear view (offset 0xFC8) clears the command status bits written as one and leaves the others unchanged.
- R4: Channel n owns command status bits [2n+1:2n]. Each field is ANDed with the command mask (offset 0xFCC). A masked value of 1 drives `cmd_start[n]`, 2 drives `cmd_pause[n]` and 3 drives `cmd_flush[n]`. At most one of the three is high per channel.
- R5: A one-cycle pulse on `cmd_ack[n]` returns channel n's command field to 0 and leaves the other channels' fields unchanged.
- R6: When a command set write and an acknowledge hit the same bit in the same cycle, the set wins and the bit ends at 1.
- R7: A pulse on `ch_done[n]` sets interrupt status bit 2n, and a pulse on `ch_err[n]` sets bit 2n+1. Interrupt status is at offset 0xFD0, its set view is at 0xFD4 and its clear view is at 0xFD8. Reads of any of these three offsets return the interrupt status.
- R8: When a channel event and a software interrupt clear hit the same bit in the same cycle, the event wins and the bit ends at 1.
- R9: `irq` is 1 exactly when some interrupt status bit is 1 and its interrupt mask bit (offset 0xFDC, 1 = enabled) is 1.
- R10: Both mask registers are written directly by a write to their offset and read back the written value.
- R11: Reads from any unmapped offset return 0. Writes to unmapped offsets, and writes to the two status offsets 0xFC0 and 0xFD0, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write |
| wr_data | input | 2*N_CH | Write data |
| rd_addr | input | 12 | Byte offset of the read |
| rd_data | output | 2*N_CH | Read data (combinational) |
| cmd_start | output | N_CH | Per-channel start command |
| cmd_pause | output | N_CH | Per-channel pause command |
| cmd_flush | output | N_CH | Per-channel flush command |
| cmd_ack | input | N_CH | Per-channel command acknowledge pulse |
| ch_done | input | N_CH | Per-channel completion event pulse |
| ch_err | input | N_CH | Per-channel error event pulse |
| irq | output | 1 | Combined interrupt |

## Verification
Two kinds of same-cycle collision can occur. On the command side, a software set write can land in the cycle a channel acknowledge clears the same field. On the interrupt side, a software clear can land in the cycle a completion event sets the same bit. The bench provokes each collision by raising the write strobe and the hardware pulse on the same clock edge. It then judges the outcome by reading the status back: the set bits must survive the acknowledge, and the event bit must survive the clear. The bits on the other channels, which no pulse touched, must follow the plain set or clear rule.

// File: rtl/chan_rf_pkg.sv
package chan_rf_pkg;

    localparam int RF_ADDR_W = 12;

    localparam logic [RF_ADDR_W-1:0] OFS_CMD_STS = 12'hFC0;
    localparam logic [RF_ADDR_W-1:0] OFS_CMD_SET = 12'hFC4;
    localparam logic [RF_ADDR_W-1:0] OFS_CMD_CLR = 12'hFC8;
    localparam logic [RF_ADDR_W-1:0] OFS_CMD_MSK = 12'hFCC;
    localparam logic [RF_ADDR_W-1:0] OFS_INT_STS = 12'hFD0;
    localparam logic [RF_ADDR_W-1:0] OFS_INT_SET = 12'hFD4;
    localparam logic [RF_ADDR_W-1:0] OFS_INT_CLR = 12'hFD8;
    localparam logic [RF_ADDR_W-1:0] OFS_INT_MSK = 12'hFDC;

    typedef enum logic [1:0] {
        FLD_IDLE  = 2'd0,
        FLD_START = 2'd1,
        FLD_PAUSE = 2'd2,
        FLD_FLUSH = 2'd3
    } cmd_code_e;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CMD_STS,
        RSEL_CMD_MSK,
        RSEL_INT_STS,
        RSEL_INT_MSK
    } rsel_e;

    typedef struct packed {
        logic cmd_set;
        logic cmd_clr;
        logic cmd_msk;
        logic int_set;
        logic int_clr;
        logic int_msk;
    } wstb_t;

    // Write strobes for one access; status offsets are read-only.
    function automatic wstb_t wr_decode(input logic en, input logic [RF_ADDR_W-1:0] a);
        wstb_t s;
        s = '0;
        if (en) begin
            s.cmd_set = (a == OFS_CMD_SET);
            s.cmd_clr = (a == OFS_CMD_CLR);
            s.cmd_msk = (a == OFS_CMD_MSK);
            s.int_set = (a == OFS_INT_SET);
            s.int_clr = (a == OFS_INT_CLR);
            s.int_msk = (a == OFS_INT_MSK);
        end
        return s;
    endfunction

    function automatic rsel_e rd_decode(input logic [RF_ADDR_W-1:0] a);
        rsel_e r;
        case (a)
            OFS_CMD_STS, OFS_CMD_SET, OFS_CMD_CLR: r = RSEL_CMD_STS;
            OFS_CMD_MSK:                           r = RSEL_CMD_MSK;
            OFS_INT_STS, OFS_INT_SET, OFS_INT_CLR: r = RSEL_INT_STS;
            OFS_INT_MSK:                           r = RSEL_INT_MSK;
            default:                               r = RSEL_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/chan_rf_decode.sv
module chan_rf_decode
    import chan_rf_pkg::*;
(
    input  logic                 wr_en,
    input  logic [RF_ADDR_W-1:0] wr_addr,
    input  logic [RF_ADDR_W-1:0] rd_addr,
    output wstb_t                wstb,
    output rsel_e                rsel
);
    always_comb begin
        wstb = wr_decode(wr_en, wr_addr);
        rsel = rd_decode(rd_addr);
    end
endmodule

// File: rtl/chan_rf_bits.sv
// Sticky status bits: software and hardware set, software and hardware clear.
// Any set outranks any clear on the same bit in the same cycle.
module chan_rf_bits #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_set_en,
    input  logic         sw_clr_en,
    input  logic [W-1:0] sw_bits,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] hw_clr,
    output logic [W-1:0] q
);
    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;
    logic [W-1:0] nxt;

    always_comb begin
        set_v = (sw_set_en ? sw_bits : '0) | hw_set;
        clr_v = (sw_clr_en ? sw_bits : '0) | hw_clr;
        nxt   = (q & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/chan_rf_cmd_out.sv
module chan_rf_cmd_out
    import chan_rf_pkg::*;
#(
    parameter int N_CH = 16,
    localparam int DW = 2 * N_CH
) (
    input  logic [DW-1:0]   fields,
    output logic [N_CH-1:0] start,
    output logic [N_CH-1:0] pause,
    output logic [N_CH-1:0] flush
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        cmd_code_e code;
        assign code     = cmd_code_e'(fields[2*i +: 2]);
        assign start[i] = (code == FLD_START);
        assign pause[i] = (code == FLD_PAUSE);
        assign flush[i] = (code == FLD_FLUSH);
    end
endmodule

// File: rtl/chan_cmd_irq_regs.sv
module chan_cmd_irq_regs
    import chan_rf_pkg::*;
#(
    parameter int N_CH = 16,
    localparam int DW = 2 * N_CH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [RF_ADDR_W-1:0] wr_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [RF_ADDR_W-1:0] rd_addr,
    output logic [DW-1:0]        rd_data,
    output logic [N_CH-1:0]      cmd_start,
    output logic [N_CH-1:0]      cmd_pause,
    output logic [N_CH-1:0]      cmd_flush,
    input  logic [N_CH-1:0]      cmd_ack,
    input  logic [N_CH-1:0]      ch_done,
    input  logic [N_CH-1:0]      ch_err,
    output logic                 irq
);
    wstb_t       wstb;
    rsel_e       rsel;
    logic [DW-1:0] cmd_q;
    logic [DW-1:0] int_q;
    logic [DW-1:0] cmd_msk_q;
    logic [DW-1:0] int_msk_q;
    logic [DW-1:0] ack_pairs;
    logic [DW-1:0] ev_pairs;

    chan_rf_decode u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wstb    (wstb),
        .rsel    (rsel)
    );

    // Per-channel pair spreading: ack clears both bits, events map done->low, err->high.
    for (genvar i = 0; i < N_CH; i++) begin : g_pair
        assign ack_pairs[2*i +: 2] = {2{cmd_ack[i]}};
        assign ev_pairs[2*i +: 2]  = {ch_err[i], ch_done[i]};
    end

    chan_rf_bits #(.W(DW)) u_cmd_bits (
        .clk       (clk),
        .rst       (rst),
        .sw_set_en (wstb.cmd_set),
        .sw_clr_en (wstb.cmd_clr),
        .sw_bits   (wr_data),
        .hw_set    ('0),
        .hw_clr    (ack_pairs),
        .q         (cmd_q)
    );

    chan_rf_bits #(.W(DW)) u_int_bits (
        .clk       (clk),
        .rst       (rst),
        .sw_set_en (wstb.int_set),
        .sw_clr_en (wstb.int_clr),
        .sw_bits   (wr_data),
        .hw_set    (ev_pairs),
        .hw_clr    ('0),
        .q         (int_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_msk_q <= '0;
            int_msk_q <= '0;
        end else begin
            if (wstb.cmd_msk) cmd_msk_q <= wr_data;
            if (wstb.int_msk) int_msk_q <= wr_data;
        end
    end

    chan_rf_cmd_out #(.N_CH(N_CH)) u_out (
        .fields (cmd_q & cmd_msk_q),
        .start  (cmd_start),
        .pause  (cmd_pause),
        .flush  (cmd_flush)
    );

    always_comb begin
        case (rsel)
            RSEL_CMD_STS: rd_data = cmd_q;
            RSEL_CMD_MSK: rd_data = cmd_msk_q;
            RSEL_INT_STS: rd_data = int_q;
            RSEL_INT_MSK: rd_data = int_msk_q;
            default:      rd_data = '0;
        endcase
    end

    assign irq = |(int_q & int_msk_q);
endmodule

// File: rtl/chan_rf_chk.sv
module chan_rf_chk
    import chan_rf_pkg::*;
#(
    parameter int N_CH = 16,
    localparam int DW = 2 * N_CH
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [RF_ADDR_W-1:0] wr_addr,
    input logic [DW-1:0]        wr_data,
    input logic [N_CH-1:0]      cmd_ack,
    input logic [N_CH-1:0]      ch_done,
    input logic [N_CH-1:0]      ch_err,
    input logic [N_CH-1:0]      cmd_start,
    input logic [N_CH-1:0]      cmd_pause,
    input logic [N_CH-1:0]      cmd_flush,
    input logic                 irq,
    input logic [DW-1:0]        cmd_q,
    input logic [DW-1:0]        int_q,
    input logic [DW-1:0]        cmd_msk_q,
    input logic [DW-1:0]        int_msk_q
);
    logic [DW-1:0] ev_vec;
    logic [DW-1:0] ack_vec;
    logic          set_hit;
    logic          mapped;
    logic          hw_quiet;

    for (genvar i = 0; i < N_CH; i++) begin : g_vec
        assign ev_vec[2*i]      = ch_done[i];
        assign ev_vec[2*i+1]    = ch_err[i];
        assign ack_vec[2*i +: 2] = {2{cmd_ack[i]}};
    end

    assign set_hit  = wr_en && (wr_addr == OFS_CMD_SET);
    assign mapped   = (wr_decode(wr_en, wr_addr) != '0);
    assign hw_quiet = (cmd_ack == '0) && (ch_done == '0) && (ch_err == '0);

    // R8
    ev_sticks_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_vec != '0) |=> ((int_q & $past(ev_vec)) == $past(ev_vec)));

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd_ack != '0) && !set_hit) |=> ((cmd_q & $past(ack_vec)) == '0));

    // R6
    set_beats_ack_chk: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> ((cmd_q & $past(wr_data)) == $past(wr_data)));

    // R9
    irq_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((int_q != '0) && (int_msk_q != '0)));

    // R11
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mapped && hw_quiet) |=>
            ($stable(cmd_q) && $stable(int_q) && $stable(cmd_msk_q) && $stable(int_msk_q)));

    // R4
    for (genvar i = 0; i < N_CH; i++) begin : g_one
        one_cmd_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0({cmd_start[i], cmd_pause[i], cmd_flush[i]}));
    end
endmodule

bind chan_cmd_irq_regs chan_rf_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmd_ack   (cmd_ack),
    .ch_done   (ch_done),
    .ch_err    (ch_err),
    .cmd_start (cmd_start),
    .cmd_pause (cmd_pause),
    .cmd_flush (cmd_flush),
    .irq       (irq),
    .cmd_q     (cmd_q),
    .int_q     (int_q),
    .cmd_msk_q (cmd_msk_q),
    .int_msk_q (int_msk_q)
);

// File: tb/chan_cmd_irq_regs_bench.sv
module chan_cmd_irq_regs_bench;
    localparam int N_CH = 16;
    localparam int DW = 2 * N_CH;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [11:0]     wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic [11:0]     rd_addr = '0;
    logic [DW-1:0]   rd_data;
    logic [N_CH-1:0] cmd_start, cmd_pause, cmd_flush;
    logic [N_CH-1:0] cmd_ack = '0;
    logic [N_CH-1:0] ch_done = '0;
    logic [N_CH-1:0] ch_err = '0;
    logic            irq;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    chan_cmd_irq_regs #(.N_CH(N_CH)) u_chan_cmd_irq_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_start(cmd_start),
        .cmd_pause(cmd_pause), .cmd_flush(cmd_flush), .cmd_ack(cmd_ack),
        .ch_done(ch_done), .ch_err(ch_err), .irq(irq)
    );

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [DW-1:0] exp, input string tag);
        rd_addr = a;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        rd(12'hFC0, '0, "R1 cmd status");
        rd(12'hFCC, '0, "R1 cmd mask");
        rd(12'hFD0, '0, "R1 int status");
        rd(12'hFDC, '0, "R1 int mask");
        check("R1 outputs", {cmd_start, cmd_pause}, '0);
        check("R1 irq", {31'b0, irq}, '0);
    endtask

    task automatic t_masks;
        wr(12'hFCC, 32'hFFFF_FFFF);
        wr(12'hFDC, 32'h0000_0000);
        rd(12'hFCC, 32'hFFFF_FFFF, "R10 cmd mask");
    endtask

    task automatic t_cmd_set_encode;
        // ch0=start(01), ch1=pause(10), ch2=flush(11)
        wr(12'hFC4, 32'h0000_0039);
        rd(12'hFC0, 32'h0000_0039, "R2 status after set");
        rd(12'hFC4, 32'h0000_0039, "R2 read via set view");
        rd(12'hFC8, 32'h0000_0039, "R2 read via clear view");
        check("R4 start", cmd_start, 16'h0001);
        check("R4 pause", cmd_pause, 16'h0002);
        check("R4 flush", cmd_flush, 16'h0004);
        wr(12'hFCC, 32'h0000_0015);
        check("R4 masked start", cmd_start, 16'h0005);
        check("R4 masked pause", cmd_pause, 16'h0000);
        check("R4 masked flush", cmd_flush, 16'h0000);
        wr(12'hFCC, 32'hFFFF_FFFF);
    endtask

    task automatic t_ack;
        @(negedge clk); cmd_ack = 16'h0004;
        @(negedge clk); cmd_ack = '0;
        rd(12'hFC0, 32'h0000_0009, "R5 ack ch2");
        check("R5 flush gone", cmd_flush, 16'h0000);
    endtask

    task automatic t_ack_set_collide;
        @(negedge clk);
        cmd_ack = 16'h0001; wr_en = 1'b1; wr_addr = 12'hFC4; wr_data = 32'h0000_0001;
        @(negedge clk);
        cmd_ack = '0; wr_en = 1'b0;
        rd(12'hFC0, 32'h0000_0009, "R6 set beats ack");
    endtask

    task automatic t_cmd_clr;
        wr(12'hFC8, 32'h0000_0008);
        rd(12'hFC0, 32'h0000_0001, "R3 clear ch1");
    endtask

    task automatic t_int_irq;
        @(negedge clk); ch_done = 16'h0008; ch_err = 16'h8000;
        @(negedge clk); ch_done = '0; ch_err = '0;
        rd(12'hFD0, 32'h8000_0040, "R7 events");
        rd(12'hFD8, 32'h8000_0040, "R7 read via clear view");
        check("R9 irq masked off", {31'b0, irq}, 32'd0);
        wr(12'hFDC, 32'h0000_0040);
        check("R9 irq enabled", {31'b0, irq}, 32'd1);
        wr(12'hFD8, 32'h0000_0040);
        rd(12'hFD0, 32'h8000_0000, "R7 sw clear");
        check("R9 irq after clear", {31'b0, irq}, 32'd0);
        wr(12'hFD4, 32'h0000_0100);
        rd(12'hFD4, 32'h8000_0100, "R7 sw set");
    endtask

    task automatic t_clr_event_collide;
        @(negedge clk);
        ch_done = 16'h0002; wr_en = 1'b1; wr_addr = 12'hFD8; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        ch_done = '0; wr_en = 1'b0;
        rd(12'hFD0, 32'h0000_0004, "R8 event beats clear");
    endtask

    task automatic t_unmapped;
        wr(12'hFE0, 32'hFFFF_FFFF);
        wr(12'hFC0, 32'hFFFF_FFFF);
        wr(12'hFD0, 32'hFFFF_FFFF);
        wr(12'hFC5, 32'hFFFF_FFFF);
        rd(12'hFE0, '0, "R11 unmapped read");
        rd(12'h000, '0, "R11 low unmapped read");
        rd(12'hFC0, 32'h0000_0001, "R11 cmd status unchanged");
        rd(12'hFD0, 32'h0000_0004, "R11 int status unchanged");
        rd(12'hFDC, 32'h0000_0040, "R10 int mask readback");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_masks;
        t_cmd_set_encode;
        t_ack;
        t_ack_set_collide;
        t_cmd_clr;
        t_int_irq;
        t_clr_event_collide;
        t_unmapped;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule